// File: doc/BRIEF.md
# Hybrid Pulse-Position Header Packet Serializer

This block turns a destination address and a stored payload into one serial packet stream, one bit per clock cycle. On a start strobe it captures the address and sends a single marker bit. A hybrid header follows. The upper address bits go out as ordinary binary. The lower address bits are encoded as a pulse-position frame: a run of slots in which exactly one slot carries a 1.

The payload is then fetched byte by byte from an external memory through a read port with one cycle of latency, and each byte is serialized. An idle guard interval of programmable length closes every packet. A busy flag covers the whole packet, guard included. A start strobe that arrives while the flag is high is ignored.

With the default parameters the address is 5 bits. Two of them stay binary and three become an 8-slot frame, so the header is 10 bits. The payload is 53 bytes.

Top module: `ppm_framer`

## Requirements
- R1: After reset, `line_o`, `busy_o` and `pay_addr_o` are all 0.
- R2: A start strobe sampled while `busy_o` is low begins a packet. In the next cycle `busy_o` is 1 and `line_o` carries the marker bit, which is 1.
- R3: The BIN_W cycles after the marker carry the upper address bits, most significant first (bits 4 and 3 by default).
- R4: The next 2^(ADDR_W-BIN_W) cycles form the position frame, with slot 0 sent first. Exactly one slot is 1, at the index equal to the value of the low address bits. Address 11001 therefore gives the header bits 1,1,0,1,0,0,0,0,0,0.
- R5: Directly after the header come PAY_BYTES bytes, byte index 0 first, each sent most significant bit first (424 bits by default).
- R6: `pay_addr_o` is a registered byte index below PAY_BYTES. The byte it selects must appear on `pay_data_i` one cycle after the index is presented.
- R7: After the last payload bit, `line_o` is 0 for exactly GUARD_CYC cycles while `busy_o` stays 1. Then `busy_o` falls, and `line_o` is 0 whenever `busy_o` is 0.
- R8: A start strobe while `busy_o` is 1 has no effect. The packet in progress is unchanged, and no further packet follows it.
- R9: If start is held high, the next marker appears after exactly one cycle with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Packet start strobe |
| addr_i | input | ADDR_W | Destination address, captured on an accepted start |
| pay_addr_o | output | $clog2(PAY_BYTES) | Payload byte index to the external memory |
| pay_data_i | input | 8 | Payload byte, one cycle after its index |
| line_o | output | 1 | Serial packet line |
| busy_o | output | 1 | High from the marker bit through the last guard cycle |

## Verification
A fault in the phase or counter logic moves the boundary between header, payload and guard. Every following bit then lands in the wrong cycle, so a single packet exposes the fault within a few hundred cycles. A wrong slot decode or wrong binary bit shows within the first eleven cycles of a packet. Sweeping all 32 addresses catches every slot position and both values of each binary bit. A payload fetch that is off by one index or one cycle of latency corrupts whole bytes, because each packet uses a payload pattern that depends on its address.

// File: rtl/ppm_framer_pkg.sv
package ppm_framer_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_HDR   = 2'd1,
    PH_PAY   = 2'd2,
    PH_GUARD = 2'd3
  } phase_t;
endpackage

// File: rtl/ppm_hdr_enc.sv
module ppm_hdr_enc #(
  parameter int ADDR_W = 5,
  parameter int BIN_W  = 2
) (
  input  logic [ADDR_W-1:0]                        addr_i,
  output logic [BIN_W+(1<<(ADDR_W-BIN_W))-1:0]    hdr_o
);
  localparam int PPM_W   = ADDR_W - BIN_W;
  localparam int SLOTS   = 1 << PPM_W;
  localparam int HDR_LEN = BIN_W + SLOTS;

  logic [PPM_W-1:0] low_val;
  assign low_val = addr_i[PPM_W-1:0];

  // binary part occupies the top of the vector so it shifts out first
  assign hdr_o[HDR_LEN-1 -: BIN_W] = addr_i[ADDR_W-1 -: BIN_W];

  // slot s is transmitted s-th, so it sits at position SLOTS-1-s
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign hdr_o[SLOTS-1-s] = (low_val == PPM_W'(s));
  end
endmodule

// File: rtl/ppm_byte_ser.sv
module ppm_byte_ser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              bit_o
);
  logic [BYTE_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)          sr <= '0;
    else if (load_i)  sr <= data_i;
    else if (shift_i) sr <= {sr[BYTE_W-2:0], 1'b0};
  end

  assign bit_o = sr[BYTE_W-1];

  p_load_shift_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(load_i && shift_i));
endmodule

// File: rtl/ppm_framer.sv
module ppm_framer
  import ppm_framer_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int BIN_W     = 2,
  parameter int PAY_BYTES = 53,
  parameter int GUARD_CYC = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [$clog2(PAY_BYTES)-1:0] pay_addr_o,
  input  logic [7:0]                   pay_data_i,
  output logic                         line_o,
  output logic                         busy_o
);
  localparam int PPM_W   = ADDR_W - BIN_W;
  localparam int SLOTS   = 1 << PPM_W;
  localparam int HDR_LEN = BIN_W + SLOTS;
  localparam int IDX_W   = $clog2(PAY_BYTES);
  localparam int CNT_MAX = (HDR_LEN > GUARD_CYC) ? HDR_LEN : GUARD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [HDR_LEN-1:0] hdr_vec;
  logic [HDR_LEN-1:0] hdr_sr;
  logic [2:0]         bit_cnt;
  logic [IDX_W-1:0]   pay_idx;
  logic               last_byte;
  logic               ser_load;
  logic               ser_shift;
  logic               ser_bit;

  ppm_hdr_enc #(.ADDR_W(ADDR_W), .BIN_W(BIN_W)) u_enc (
    .addr_i (addr_i),
    .hdr_o  (hdr_vec)
  );

  assign ser_load  = ((phase == PH_HDR) && (cnt == '0)) ||
                     ((phase == PH_PAY) && (bit_cnt == 3'd7) && !last_byte);
  assign ser_shift = (phase == PH_PAY) && (bit_cnt != 3'd7);

  ppm_byte_ser #(.BYTE_W(8)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ser_load),
    .shift_i (ser_shift),
    .data_i  (pay_data_i),
    .bit_o   (ser_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      hdr_sr    <= '0;
      bit_cnt   <= '0;
      pay_idx   <= '0;
      last_byte <= 1'b0;
      line_o    <= 1'b0;
      busy_o    <= 1'b0;
    end else begin
      // fetch pointer advances with each byte taken into the serializer
      if (ser_load) begin
        if (pay_idx == IDX_W'(PAY_BYTES-1)) begin
          pay_idx   <= '0;
          last_byte <= 1'b1;
        end else begin
          pay_idx <= pay_idx + 1'b1;
        end
      end
      unique case (phase)
        PH_IDLE: begin
          line_o <= 1'b0;
          if (start_i) begin
            phase  <= PH_HDR;
            hdr_sr <= hdr_vec;
            cnt    <= CNT_W'(HDR_LEN-1);
            line_o <= 1'b1;
            busy_o <= 1'b1;
          end
        end
        PH_HDR: begin
          line_o <= hdr_sr[HDR_LEN-1];
          hdr_sr <= {hdr_sr[HDR_LEN-2:0], 1'b0};
          if (cnt == '0) begin
            phase   <= PH_PAY;
            bit_cnt <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_PAY: begin
          line_o  <= ser_bit;
          bit_cnt <= bit_cnt + 1'b1;
          if ((bit_cnt == 3'd7) && last_byte) begin
            phase     <= PH_GUARD;
            last_byte <= 1'b0;
            cnt       <= CNT_W'(GUARD_CYC);
          end
        end
        PH_GUARD: begin
          line_o <= 1'b0;
          if (cnt == '0) begin
            phase  <= PH_IDLE;
            busy_o <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign pay_addr_o = pay_idx;

  p_marker_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> line_o);

  p_one_slot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot(hdr_vec[SLOTS-1:0]));

  p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
    pay_addr_o < IDX_W'(PAY_BYTES));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !line_o);

  p_guard_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GUARD) |=> !line_o);

  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PAY) |=> (phase != PH_HDR));
endmodule

// File: tb/ppm_framer_test.sv
module ppm_framer_test;
  localparam int ADDR_W    = 5;
  localparam int BIN_W     = 2;
  localparam int PAY_BYTES = 53;
  localparam int GUARD_CYC = 16;
  localparam int SLOTS     = 1 << (ADDR_W - BIN_W);
  localparam int HDR_LEN   = BIN_W + SLOTS;
  localparam int PAY_BITS  = PAY_BYTES * 8;
  localparam int TOTAL     = 1 + HDR_LEN + PAY_BITS + GUARD_CYC;
  localparam int IDX_W     = $clog2(PAY_BYTES);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [IDX_W-1:0]  pay_addr_o;
  logic [7:0]        pay_data_i;
  logic              line_o;
  logic              busy_o;

  int checks = 0;
  int errors = 0;
  int tag = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ppm_framer #(.ADDR_W(ADDR_W), .BIN_W(BIN_W), .PAY_BYTES(PAY_BYTES),
               .GUARD_CYC(GUARD_CYC)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .pay_addr_o(pay_addr_o), .pay_data_i(pay_data_i),
    .line_o(line_o), .busy_o(busy_o));

  function automatic logic [7:0] pat(input int t, input int i);
    return 8'((t * 37 + i * 91 + 5) ^ (i << 2));
  endfunction

  // memory model with one cycle read latency (R6)
  always_ff @(posedge clk) pay_data_i <= pat(tag, int'(pay_addr_o));

  function automatic logic exp_bit(input int a, input int k);
    int s, p;
    if (k == 0) return 1'b1;
    if (k <= BIN_W) return 1'((a >> (ADDR_W - k)) & 1);
    if (k <= HDR_LEN) begin
      s = k - 1 - BIN_W;
      return (s == (a % SLOTS));
    end
    p = k - 1 - HDR_LEN;
    if (p < PAY_BITS) return pat(a, p / 8)[7 - (p % 8)];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // starts a packet and checks every bit; glitch injects a start mid-packet
  task automatic run_packet(input int a, input bit glitch);
    int e_mark, e_bin, e_ppm, e_pay, e_grd, e_busy;
    e_mark = 0; e_bin = 0; e_ppm = 0; e_pay = 0; e_grd = 0; e_busy = 0;
    @(negedge clk);
    tag = a;
    addr_i = ADDR_W'(a);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < TOTAL; k++) begin
      if (line_o !== exp_bit(a, k)) begin
        if (k == 0) e_mark++;
        else if (k <= BIN_W) e_bin++;
        else if (k <= HDR_LEN) e_ppm++;
        else if (k <= HDR_LEN + PAY_BITS) e_pay++;
        else e_grd++;
      end
      if (busy_o !== 1'b1) e_busy++;
      if (glitch && (k == 5 || k == 200 || k == TOTAL - 2)) begin
        start_i = 1'b1;
        addr_i = ADDR_W'(a ^ 5);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    check(e_mark == 0, "R2 marker", e_mark, 0);
    check(e_bin == 0, "R3 binary bits", e_bin, 0);
    check(e_ppm == 0, "R4 slot frame", e_ppm, 0);
    check(e_pay == 0, "R5 R6 payload", e_pay, 0);
    check(e_grd == 0, "R7 guard zeros", e_grd, 0);
    check(e_busy == 0, "R7 busy span", e_busy, 0);
    check(busy_o == 1'b0 && line_o == 1'b0, "R7 end of packet",
          int'({busy_o, line_o}), 0);
  endtask

  initial begin
    int hi_cnt, lo_cnt, quiet;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(line_o == 1'b0, "R1 line after reset", int'(line_o), 0);
    check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    check(pay_addr_o == '0, "R1 index after reset", int'(pay_addr_o), 0);

    // known vector: 11001 -> 1 | 11 | 01000000
    run_packet(25, 1'b0);

    // sweep of every address
    for (int a = 0; a < (1 << ADDR_W); a++) run_packet(a, 1'b0);

    // starts during busy are ignored (R8)
    run_packet(19, 1'b1);
    quiet = 0;
    for (int i = 0; i < 40; i++) begin
      if (busy_o !== 1'b0 || line_o !== 1'b0) quiet++;
      @(negedge clk);
    end
    check(quiet == 0, "R8 no packet after ignored start", quiet, 0);

    // start held high: one idle cycle between packets (R9)
    tag = 7;
    addr_i = ADDR_W'(7);
    start_i = 1'b1;
    while (busy_o !== 1'b1) @(negedge clk);
    hi_cnt = 0;
    while (busy_o === 1'b1) begin hi_cnt++; @(negedge clk); end
    lo_cnt = 0;
    while (busy_o !== 1'b1) begin lo_cnt++; @(negedge clk); end
    check(hi_cnt == TOTAL, "R9 packet length", hi_cnt, TOTAL);
    check(lo_cnt == 1, "R9 gap between packets", lo_cnt, 1);
    check(line_o == 1'b1, "R9 marker of second packet", int'(line_o), 1);
    start_i = 1'b0;
    while (busy_o === 1'b1) @(negedge clk);

    // reset mid-packet returns to idle state (R1)
    run_packet_abort();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic run_packet_abort();
    @(negedge clk);
    addr_i = ADDR_W'(3);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy_o == 1'b0 && line_o == 1'b0 && pay_addr_o == '0,
          "R1 reset during packet", int'({busy_o, line_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule